// File: doc/BRIEF.md
# Radix-2 Delay-Feedback FFT Stage with Selectable Word Truncation

This block is one pipelined radix-2 decimation-in-frequency stage for a streaming complex FFT. It is built on a single-path delay-feedback structure. Complex samples arrive one per cycle while `in_valid` is high. The first half of each span of samples is parked in a delay line of span/2 entries. During the second half, each arriving sample is combined with the sample parked half a span earlier. The sum leaves the stage at once. The difference goes back into the delay line. During the first half of the next span, that difference is read back out, optionally rotated by a twiddle factor, and emitted.

The butterfly grows the word by one bit. A per-instance parameter decides how the stage returns to the working width. It can discard the top bit, which wraps. It can discard the bottom bit, which halves the value. It can also keep the grown word, so that the next stage simply starts one bit wider. A 4096-point transform is a chain of twelve of these stages with spans 4096, 2048 and so on down to 2. Each stage can pick its own rule; for example, early stages can halve and late stages can wrap, and the package function `fft_sdf_pkg::split_mode` computes such a per-stage choice. The last stage (span 2) never multiplies.

Top module: `fft_sdf_stage`

## Requirements
- R1: After reset, the first SPAN/2 valid samples of each span are only stored, and they produce no output. `out_valid` first rises in the cycle after the first valid sample of the second half of a span.
- R2: For valid sample k (0 ≤ k < SPAN/2) of the second half, the output one cycle later is the truncation of (stored sample k + current sample). The sum is formed at IN_W+1 bits.
- R3: The difference (stored sample k − current sample) is emitted one cycle after valid sample k of the next span's first half. Before truncation it is multiplied by exp(−j2πk/SPAN). The coefficients are round(16384·cos) and round(16384·sin), with rounding done as floor(x+0.5). The product is rounded by adding 2^13 and shifting right arithmetically by 14, then saturated to the signed IN_W+1 range. For k = 0 the difference passes unchanged.
- R4: In drop-top mode (TRUNC_MODE = TRUNC_DROP_MSB), the output keeps bits [IN_W-1:0] of the IN_W+1 bit result, so overflow wraps.
- R5: In drop-bottom mode (TRUNC_MODE = TRUNC_DROP_LSB), the output keeps bits [IN_W:1], which is an arithmetic shift right by one.
- R6: In keep mode (TRUNC_MODE = TRUNC_KEEP), the output is the full IN_W+1 bit result and the output ports are IN_W+1 bits wide.
- R7: When HAS_TWID is 0, or when SPAN is 2, the difference is emitted without rotation.
- R8: A cycle with `in_valid` low advances nothing. `out_valid` is low in the following cycle, and the output data hold their value.
- R9: An active-low asynchronous reset clears the span counter, the primed state, the delay contents, `out_valid` and the output data to zero. Stimulus that arrived before the reset has no effect on later outputs.
- R10: Once primed, every valid input yields exactly one valid output in the next cycle. No output appears without a valid input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input sample present this cycle |
| in_re | input | IN_W | Input real part, two's complement |
| in_im | input | IN_W | Input imaginary part, two's complement |
| out_valid | output | 1 | Output sample present |
| out_re | output | OUT_W | Output real part (IN_W, or IN_W+1 in keep mode) |
| out_im | output | OUT_W | Output imaginary part |

## Verification
In the same cycle, the stage reads out the rotated difference of the previous span and writes the new span's raw input into the same delay slot. The bench provokes this overlap by running spans back to back with no idle cycle, and again with idle cycles between every sample. Both runs must produce the same output stream, and each output is compared with a reference computed in the bench from R2 and R3. A reset in the middle of a span then checks that the overlap starts over cleanly from an empty delay line.

// File: rtl/fft_sdf_pkg.sv
package fft_sdf_pkg;

  // Rule used to bring the one-bit-grown butterfly word back to width
  typedef enum logic [1:0] {
    TRUNC_DROP_MSB = 2'd0,
    TRUNC_DROP_LSB = 2'd1,
    TRUNC_KEEP     = 2'd2
  } trunc_mode_e;

  localparam int COEF_W    = 16;
  localparam int COEF_FRAC = 14;

  function automatic int out_width(int in_w, trunc_mode_e mode);
    return (mode == TRUNC_KEEP) ? in_w + 1 : in_w;
  endfunction

  // Per-stage selection for a chain: stages below split_at use the early rule
  function automatic trunc_mode_e split_mode(int stage_idx, int split_at,
                                             trunc_mode_e early_mode,
                                             trunc_mode_e late_mode);
    return (stage_idx < split_at) ? early_mode : late_mode;
  endfunction

endpackage

// File: rtl/sdf_ctrl.sv
module sdf_ctrl #(
  parameter int SPAN = 16,
  localparam int CW  = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int KW  = (CW > 1) ? CW - 1 : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  output logic          bfly,
  output logic [KW-1:0] k,
  output logic          primed
);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          primed_q, primed_d;

  always_comb begin
    cnt_d    = cnt_q;
    primed_d = primed_q;
    if (adv) begin
      cnt_d    = cnt_q + 1'b1;
      primed_d = primed_q | cnt_q[CW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      primed_q <= 1'b0;
    end else begin
      cnt_q    <= cnt_d;
      primed_q <= primed_d;
    end
  end

  assign bfly   = cnt_q[CW-1];
  assign primed = primed_q;

  generate
    if (CW > 1) begin : g_idx
      assign k = cnt_q[CW-2:0];
    end else begin : g_idx1
      assign k = '0;
    end
  endgenerate

  // R8
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !adv |=> $stable(cnt_q));

  // R1
  wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && cnt_q == CW'(SPAN - 1)) |=> (cnt_q == '0));

  // R1
  primed_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(primed_q));

endmodule

// File: rtl/sdf_delay.sv
module sdf_delay #(
  parameter int DEPTH = 8,
  parameter int W     = 21,
  parameter int AW    = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       addr,
  input  logic signed [W-1:0] wr_re,
  input  logic signed [W-1:0] wr_im,
  output logic signed [W-1:0] rd_re,
  output logic signed [W-1:0] rd_im
);

  generate
    if (DEPTH == 1) begin : g_single
      logic signed [W-1:0] re_q, im_q, re_d, im_d;
      logic unused_addr;
      assign unused_addr = ^addr;

      always_comb begin
        re_d = re_q;
        im_d = im_q;
        if (we) begin
          re_d = wr_re;
          im_d = wr_im;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          re_q <= '0;
          im_q <= '0;
        end else begin
          re_q <= re_d;
          im_q <= im_d;
        end
      end

      assign rd_re = re_q;
      assign rd_im = im_q;
    end else begin : g_ring
      logic signed [W-1:0] mem_re_q [DEPTH];
      logic signed [W-1:0] mem_im_q [DEPTH];
      logic signed [W-1:0] mem_re_d [DEPTH];
      logic signed [W-1:0] mem_im_d [DEPTH];

      always_comb begin
        mem_re_d = mem_re_q;
        mem_im_d = mem_im_q;
        if (we) begin
          mem_re_d[addr] = wr_re;
          mem_im_d[addr] = wr_im;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          for (int i = 0; i < DEPTH; i++) begin
            mem_re_q[i] <= '0;
            mem_im_q[i] <= '0;
          end
        end else begin
          mem_re_q <= mem_re_d;
          mem_im_q <= mem_im_d;
        end
      end

      assign rd_re = mem_re_q[addr];
      assign rd_im = mem_im_q[addr];
    end
  endgenerate

endmodule

// File: rtl/sdf_rotator.sv
module sdf_rotator
  import fft_sdf_pkg::*;
#(
  parameter int SPAN   = 16,
  parameter int W      = 21,
  parameter int KW     = 3,
  parameter bit USE_TW = 1'b1
) (
  input  logic [KW-1:0]       k,
  input  logic signed [W-1:0] d_re,
  input  logic signed [W-1:0] d_im,
  output logic signed [W-1:0] r_re,
  output logic signed [W-1:0] r_im
);

  localparam int HALF = SPAN / 2;
  localparam int PW   = W + COEF_W + 1;

  generate
    if (USE_TW) begin : g_rot
      localparam real PI_R = 3.14159265358979323846;
      localparam logic signed [PW-1:0] RND  = PW'(1) <<< (COEF_FRAC - 1);
      localparam logic signed [PW-1:0] MAXV = PW'((64'sd1 <<< (W - 1)) - 1);
      localparam logic signed [PW-1:0] MINV = -(PW'(64'sd1 <<< (W - 1)));

      logic signed [COEF_W-1:0] cos_t [HALF];
      logic signed [COEF_W-1:0] sin_t [HALF];

      for (genvar g = 0; g < HALF; g++) begin : g_tab
        localparam real ANG = 2.0 * PI_R * g / SPAN;
        assign cos_t[g] = COEF_W'($rtoi($floor(16384.0 * $cos(ANG) + 0.5)));
        assign sin_t[g] = COEF_W'($rtoi($floor(16384.0 * $sin(ANG) + 0.5)));
      end

      logic signed [COEF_W-1:0] c, s;
      logic signed [PW-1:0]     p_re, p_im, q_re, q_im;

      assign c = cos_t[k];
      assign s = sin_t[k];

      always_comb begin
        // (d_re + j d_im) * (c - j s)
        p_re = PW'(d_re) * PW'(c) + PW'(d_im) * PW'(s);
        p_im = PW'(d_im) * PW'(c) - PW'(d_re) * PW'(s);
        q_re = (p_re + RND) >>> COEF_FRAC;
        q_im = (p_im + RND) >>> COEF_FRAC;
        if (q_re > MAXV)      r_re = W'(MAXV);
        else if (q_re < MINV) r_re = W'(MINV);
        else                  r_re = W'(q_re);
        if (q_im > MAXV)      r_im = W'(MAXV);
        else if (q_im < MINV) r_im = W'(MINV);
        else                  r_im = W'(q_im);
      end

      // R3
      always_comb begin
        if (k == '0) begin
          unity_twiddle_chk: assert (r_re == d_re && r_im == d_im);
        end
      end
    end else begin : g_pass
      logic unused_k;
      assign unused_k = ^k;
      assign r_re = d_re;
      assign r_im = d_im;
    end
  endgenerate

endmodule

// File: rtl/fft_sdf_stage.sv
module fft_sdf_stage
  import fft_sdf_pkg::*;
#(
  parameter int          SPAN       = 16,
  parameter int          IN_W       = 20,
  parameter bit          HAS_TWID   = 1'b1,
  parameter trunc_mode_e TRUNC_MODE = TRUNC_DROP_LSB,
  localparam int         OUT_W      = out_width(IN_W, TRUNC_MODE)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic signed [IN_W-1:0]  in_re,
  input  logic signed [IN_W-1:0]  in_im,
  output logic                    out_valid,
  output logic signed [OUT_W-1:0] out_re,
  output logic signed [OUT_W-1:0] out_im
);

  localparam int  HALF   = SPAN / 2;
  localparam int  BW     = IN_W + 1;
  localparam int  CW     = $clog2(SPAN);
  localparam int  KW     = (CW > 1) ? CW - 1 : 1;
  localparam bit  USE_TW = HAS_TWID && (SPAN > 2);

  logic          bfly, primed;
  logic [KW-1:0] k;

  sdf_ctrl #(.SPAN(SPAN)) u_ctrl (
    .clk    (clk),
    .rst_n  (rst_n),
    .adv    (in_valid),
    .bfly   (bfly),
    .k      (k),
    .primed (primed)
  );

  logic signed [BW-1:0] ext_re, ext_im;
  logic signed [BW-1:0] d_re, d_im;
  logic signed [BW-1:0] sum_re, sum_im, dif_re, dif_im;
  logic signed [BW-1:0] wr_re, wr_im;
  logic signed [BW-1:0] rot_re, rot_im;
  logic signed [BW-1:0] pre_re, pre_im;

  assign ext_re = {in_re[IN_W-1], in_re};
  assign ext_im = {in_im[IN_W-1], in_im};

  // Butterfly: stored sample is the earlier half
  assign sum_re = d_re + ext_re;
  assign sum_im = d_im + ext_im;
  assign dif_re = d_re - ext_re;
  assign dif_im = d_im - ext_im;

  // Fill phase parks the input; butterfly phase parks the difference
  assign wr_re = bfly ? dif_re : ext_re;
  assign wr_im = bfly ? dif_im : ext_im;

  sdf_delay #(.DEPTH(HALF), .W(BW), .AW(KW)) u_delay (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (in_valid),
    .addr  (k),
    .wr_re (wr_re),
    .wr_im (wr_im),
    .rd_re (d_re),
    .rd_im (d_im)
  );

  sdf_rotator #(.SPAN(SPAN), .W(BW), .KW(KW), .USE_TW(USE_TW)) u_rot (
    .k    (k),
    .d_re (d_re),
    .d_im (d_im),
    .r_re (rot_re),
    .r_im (rot_im)
  );

  assign pre_re = bfly ? sum_re : rot_re;
  assign pre_im = bfly ? sum_im : rot_im;

  logic signed [OUT_W-1:0] tr_re, tr_im;

  generate
    if (TRUNC_MODE == TRUNC_KEEP) begin : g_keep
      assign tr_re = pre_re;
      assign tr_im = pre_im;
    end else if (TRUNC_MODE == TRUNC_DROP_LSB) begin : g_drop_lsb
      assign tr_re = OUT_W'(pre_re >>> 1);
      assign tr_im = OUT_W'(pre_im >>> 1);
    end else begin : g_drop_msb
      assign tr_re = OUT_W'(pre_re);
      assign tr_im = OUT_W'(pre_im);
    end
  endgenerate

  logic                    out_en;
  logic                    ov_q, ov_d;
  logic signed [OUT_W-1:0] ore_q, ore_d, oim_q, oim_d;

  assign out_en = in_valid & (primed | bfly);

  always_comb begin
    ov_d  = out_en;
    ore_d = ore_q;
    oim_d = oim_q;
    if (out_en) begin
      ore_d = tr_re;
      oim_d = tr_im;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q  <= 1'b0;
      ore_q <= '0;
      oim_q <= '0;
    end else begin
      ov_q  <= ov_d;
      ore_q <= ore_d;
      oim_q <= oim_d;
    end
  end

  assign out_valid = ov_q;
  assign out_re    = ore_q;
  assign out_im    = oim_q;

  // R10
  valid_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid));

  // R8
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(out_re) && $stable(out_im)));

  // R1
  no_early_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !primed && !bfly) |=> !out_valid);

endmodule

// File: tb/fft_sdf_stage_bench.sv
module fft_sdf_stage_bench;
  import fft_sdf_pkg::*;

  localparam int NI = 4;
  localparam int SP [NI] = '{16, 16, 16, 2};
  localparam int MD [NI] = '{1, 0, 2, 1};   // 0 drop-top, 1 drop-bottom, 2 keep
  localparam bit TW [NI] = '{1'b1, 1'b1, 1'b1, 1'b0};

  localparam int TBL_RE [32] = '{
    100000, -250000, 524287, -524288, 7, -7, 0, 333333,
    12345, -54321, 200000, -1, 524287, 1, -300000, 42,
    1000, 2000, 3000, 4000, 5000, 6000, 7000, 8000,
    -8000, -7000, -6000, -5000, -4000, -3000, -2000, -1000};
  localparam int TBL_IM [32] = '{
    0, 50000, -524288, 524287, 99, -99, 123456, 0,
    -12345, 54321, -200000, 1, -524288, 0, 300000, -42,
    -5000, 0, 5000, 10000, 15000, 20000, 25000, 30000,
    400000, -400000, 400000, -400000, 0, 0, 1, -1};

  logic clk, rst_n, in_valid;
  logic signed [19:0] in_re, in_im;
  logic [NI-1:0] ov;
  logic signed [19:0] o0_re, o0_im, o1_re, o1_im, o3_re, o3_im;
  logic signed [20:0] o2_re, o2_im;
  int got_re [NI];
  int got_im [NI];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  fft_sdf_stage #(.SPAN(16), .IN_W(20), .HAS_TWID(1'b1),
                  .TRUNC_MODE(TRUNC_DROP_LSB)) u_fft_sdf_stage (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[0]), .out_re(o0_re), .out_im(o0_im));

  fft_sdf_stage #(.SPAN(16), .IN_W(20), .HAS_TWID(1'b1),
                  .TRUNC_MODE(split_mode(7, 6, TRUNC_DROP_LSB, TRUNC_DROP_MSB))) u_msb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[1]), .out_re(o1_re), .out_im(o1_im));

  fft_sdf_stage #(.SPAN(16), .IN_W(20), .HAS_TWID(1'b1),
                  .TRUNC_MODE(TRUNC_KEEP)) u_keep (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[2]), .out_re(o2_re), .out_im(o2_im));

  fft_sdf_stage #(.SPAN(2), .IN_W(20), .HAS_TWID(1'b1),
                  .TRUNC_MODE(TRUNC_DROP_LSB)) u_last (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_re(in_re), .in_im(in_im),
    .out_valid(ov[3]), .out_re(o3_re), .out_im(o3_im));

  assign got_re[0] = int'(o0_re);  assign got_im[0] = int'(o0_im);
  assign got_re[1] = int'(o1_re);  assign got_im[1] = int'(o1_im);
  assign got_re[2] = int'(o2_re);  assign got_im[2] = int'(o2_im);
  assign got_re[3] = int'(o3_re);  assign got_im[3] = int'(o3_im);

  int checks, fails;
  bit ignore, done, last_vin;
  string cur_tag;
  int st_re[$], st_im[$];
  int exp_re [NI][$];
  int exp_im [NI][$];

  function automatic string inst_tag(int i);
    case (i)
      0: return "R5";
      1: return "R4";
      2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(bit ok, string tag, int inst, int are, int aim, int ere, int eim);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s inst %0d: actual (%0d,%0d) expected (%0d,%0d)",
               tag, inst, are, aim, ere, eim);
    end
  endtask

  function automatic int trunc_ref(int v, int mode);
    int t;
    case (mode)
      0: begin t = v & 32'h000F_FFFF; if (t >= 524288) t -= 1048576; return t; end
      1: return v >>> 1;
      default: return v;
    endcase
  endfunction

  task automatic rot_ref(int dr, int di, int k, int sp, output int rr, output int ri);
    real ang;
    longint c, s, pr, pi;
    ang = 2.0 * 3.14159265358979323846 * k / sp;
    c  = longint'($rtoi($floor(16384.0 * $cos(ang) + 0.5)));
    s  = longint'($rtoi($floor(16384.0 * $sin(ang) + 0.5)));
    pr = (longint'(dr) * c + longint'(di) * s + 8192) >>> 14;
    pi = (longint'(di) * c - longint'(dr) * s + 8192) >>> 14;
    if (pr > 1048575) pr = 1048575;
    if (pr < -1048576) pr = -1048576;
    if (pi > 1048575) pi = 1048575;
    if (pi < -1048576) pi = -1048576;
    rr = int'(pr);
    ri = int'(pi);
  endtask

  // Expected stream per R1, R2, R3: sums of span f, then its differences
  task automatic build_expected();
    for (int i = 0; i < NI; i++) begin
      int sp, h, n;
      sp = SP[i]; h = sp / 2; n = st_re.size();
      exp_re[i].delete(); exp_im[i].delete();
      for (int f = 0; (f + 1) * sp <= n; f++) begin
        for (int k = 0; k < h; k++) begin
          exp_re[i].push_back(trunc_ref(st_re[f*sp+k] + st_re[f*sp+h+k], MD[i]));
          exp_im[i].push_back(trunc_ref(st_im[f*sp+k] + st_im[f*sp+h+k], MD[i]));
        end
        if ((f + 1) * sp + h <= n) begin
          for (int k = 0; k < h; k++) begin
            int dr, di, rr, ri;
            dr = st_re[f*sp+k] - st_re[f*sp+h+k];
            di = st_im[f*sp+k] - st_im[f*sp+h+k];
            if (TW[i]) rot_ref(dr, di, k, sp, rr, ri);
            else begin rr = dr; ri = di; end
            exp_re[i].push_back(trunc_ref(rr, MD[i]));
            exp_im[i].push_back(trunc_ref(ri, MD[i]));
          end
        end
      end
    end
  endtask

  always @(posedge clk) last_vin <= in_valid;

  always begin
    @(negedge clk);
    #1;
    if (rst_n && !ignore) begin
      for (int i = 0; i < NI; i++) begin
        if (!last_vin && ov[i])
          chk(1'b0, "R8", i, 1, 0, 0, 0);
        if (ov[i]) begin
          if (exp_re[i].size() == 0) begin
            chk(1'b0, "R10", i, got_re[i], got_im[i], 0, 0);
          end else begin
            int er, ei;
            er = exp_re[i].pop_front();
            ei = exp_im[i].pop_front();
            chk(got_re[i] == er && got_im[i] == ei,
                {cur_tag, "/", inst_tag(i)}, i, got_re[i], got_im[i], er, ei);
          end
        end
      end
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < NI; i++)   // R9
      chk(!ov[i] && got_re[i] == 0 && got_im[i] == 0, "R9", i,
          got_re[i], got_im[i], 0, 0);
    rst_n = 1'b1;
  endtask

  task automatic drive(int gap);
    for (int n = 0; n < st_re.size(); n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = 20'(st_re[n]);
      in_im = 20'(st_im[n]);
      for (int g = 0; g < gap; g++) begin
        @(negedge clk);
        in_valid = 1'b0;
        in_re = 20'(n * 37);
        in_im = -20'(n * 11);
      end
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < NI; i++)   // R10: no output left missing
      chk(exp_re[i].size() == 0, "R10", i, exp_re[i].size(), 0, 0, 0);
  endtask

  task automatic load_table();
    st_re.delete(); st_im.delete();
    for (int n = 0; n < 32; n++) begin
      st_re.push_back(TBL_RE[n]);
      st_im.push_back(TBL_IM[n]);
    end
    for (int n = 0; n < 8; n++) begin
      st_re.push_back(0);
      st_im.push_back(0);
    end
  endtask

  initial begin
    checks = 0; fails = 0; ignore = 1'b0; done = 1'b0;
    rst_n = 1'b0; in_valid = 1'b0; in_re = '0; in_im = '0;
    cur_tag = "R9";
    do_reset();

    // Table walk, back to back: R2, R3
    cur_tag = "R2";
    load_table();
    build_expected();
    drive(0);

    // Same table with idle cycles between samples: R8
    cur_tag = "R8";
    do_reset();
    build_expected();
    drive(2);

    // Extremes: wrap in drop-top mode, saturation in the rotator (R4, R3)
    cur_tag = "R3";
    do_reset();
    st_re.delete(); st_im.delete();
    for (int n = 0; n < 16; n++) begin st_re.push_back(524287); st_im.push_back(-524288); end
    for (int n = 0; n < 16; n++) begin
      st_re.push_back(n < 8 ? 524287 : -524288);
      st_im.push_back(n < 8 ? -524288 : 524287);
    end
    for (int n = 0; n < 8; n++) begin st_re.push_back(0); st_im.push_back(0); end
    build_expected();
    drive(0);

    // Mid-span reset, then fresh priming: R9, R1
    cur_tag = "R1";
    do_reset();
    ignore = 1'b1;
    for (int n = 0; n < 12; n++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_re = 20'(TBL_RE[n]);
      in_im = 20'(TBL_IM[n]);
    end
    @(negedge clk);
    rst_n = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    #1;
    for (int i = 0; i < NI; i++)   // R9
      chk(!ov[i] && got_re[i] == 0 && got_im[i] == 0, "R9", i,
          got_re[i], got_im[i], 0, 0);
    @(negedge clk);
    rst_n = 1'b1;
    ignore = 1'b0;
    load_table();
    build_expected();
    drive(1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule